// File: doc/BRIEF.md
# Pipeline Branch and Jump Control

This unit steers instruction flow in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Fetch always assumes the next address is the current PC plus 4. Jumps are recognised in decode. Conditional branches, which test whether an operand is zero, are resolved in execute. The unit looks at the opcodes in decode and execute, the source specifiers and read enables in decode, the destination specifiers and write enables of the three later stages, and the execute-stage zero flag.

From these it produces four controls: the next-PC source select, the source of the decode instruction register (fetched instruction, bubble or hold), the source of the execute instruction register (decode IR or bubble), and a read-after-write stall. When control hazards conflict, the older instruction in execute wins. A taken branch therefore overrides a jump in decode and cancels any stall raised for the decode instruction, because that instruction is being killed.

The unit also holds the fetch PC register and forms the three redirect targets, so the PC sequence can be checked at the ports. The datapath, register file, memories and ALU sit outside it.

Top module: `hz_ctrl_top`

## Requirements
- R1: The raw stall is high when a decode source matches the destination of a write-enabled instruction in execute, memory or writeback. A source is rs with its read enable, or rt with its read enable. `stall_o` equals this raw stall while no branch is taken.
- R2: A branch is taken when the execute opcode is BEQZ (6'h04) with `zero_e_i` set, or BNEZ (6'h05) with `zero_e_i` clear. While a branch is taken, `stall_o` is low.
- R3: `pc_sel_o` is chosen in this priority order: 3 (branch) when a branch is taken; else 1 (absolute) for J (6'h02) or JAL (6'h03) in decode; else 2 (register) for JR (6'h12) or JALR (6'h13) in decode; else 0 (sequential).
- R4: `ir_d_sel_o` is 1 (bubble) when a branch is taken. Otherwise it is 2 (hold) when stall is high, otherwise 1 (bubble) when decode holds any jump, otherwise 0 (fetched instruction).
- R5: `ir_e_sel_o` is 1 (bubble) when a branch is taken or stall is high, and 0 (pass the decode IR) otherwise.
- R6: On each rising clock edge, `pc_o` loads the target chosen by `pc_sel_o`. While `stall_o` is high, `pc_o` holds its value.
- R7: The targets are as follows. Branch: `pc_e_i` plus the sign-extended `br_off_e_i`. Absolute: `pc_d_i` bits [31:28], then `jmp_tgt_d_i`, then 2'b00. Register: `rind_tgt_d_i`. Sequential: `pc_o` + 4.
- R8: While `rst_ni` is low, `pc_o` is `RESET_PC` (default 32'h100) and both IR selects are 1 (bubble).
- R9: A taken branch together with a jump in decode selects the branch target and bubbles both IRs. A jump alone kills only the one instruction behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_d_i | input | 6 | Decode-stage opcode |
| opcode_e_i | input | 6 | Execute-stage opcode |
| zero_e_i | input | 1 | Execute operand equals zero |
| rs_d_i | input | 5 | Decode first source register |
| rs_rd_en_d_i | input | 1 | Decode reads rs |
| rt_d_i | input | 5 | Decode second source register |
| rt_rd_en_d_i | input | 1 | Decode reads rt |
| wr_reg_e_i | input | 5 | Execute destination register |
| wr_en_e_i | input | 1 | Execute writes a register |
| wr_reg_m_i | input | 5 | Memory destination register |
| wr_en_m_i | input | 1 | Memory writes a register |
| wr_reg_w_i | input | 5 | Writeback destination register |
| wr_en_w_i | input | 1 | Writeback writes a register |
| pc_d_i | input | 32 | PC of decode instruction |
| pc_e_i | input | 32 | PC of execute instruction |
| br_off_e_i | input | 16 | Branch byte offset, signed |
| jmp_tgt_d_i | input | 26 | Absolute jump target field |
| rind_tgt_d_i | input | 32 | Register value for indirect jumps |
| stall_o | output | 1 | Read-after-write stall |
| pc_sel_o | output | 2 | Next-PC source select |
| ir_d_sel_o | output | 2 | Decode IR source select |
| ir_e_sel_o | output | 1 | Execute IR source select |
| pc_o | output | 32 | Fetch PC |

## Verification
The assertions assume the inputs are settled before each rising edge and stay constant through the cycle they describe. They also assume the execute-stage PC and offset at an edge belong to the branch being resolved at that edge. The stimulus changes every input only on the falling edge. It supplies a complete decode/execute context each cycle, with the PC inputs held at fixed values so that targets are known. Specifier values are chosen so that exactly one writer stage matches when a stall is intended, and no stage matches otherwise.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned OP_W = 6;
  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OPC_J    = 6'h02;
  localparam opcode_t OPC_JAL  = 6'h03;
  localparam opcode_t OPC_BEQZ = 6'h04;
  localparam opcode_t OPC_BNEZ = 6'h05;
  localparam opcode_t OPC_JR   = 6'h12;
  localparam opcode_t OPC_JALR = 6'h13;

  typedef enum logic [1:0] {
    PC_SEQ  = 2'd0,
    PC_JABS = 2'd1,
    PC_RIND = 2'd2,
    PC_BR   = 2'd3
  } pc_sel_e;

  typedef enum logic [1:0] {
    IRD_FETCH  = 2'd0,
    IRD_BUBBLE = 2'd1,
    IRD_HOLD   = 2'd2
  } ird_sel_e;

  typedef enum logic {
    IRE_PASS   = 1'b0,
    IRE_BUBBLE = 1'b1
  } ire_sel_e;
endpackage

// File: rtl/hz_op_decode.sv
module hz_op_decode
  import hz_pkg::*;
(
  input  opcode_t opcode_d_i,
  input  opcode_t opcode_e_i,
  input  logic    zero_e_i,
  output logic    br_taken_o,
  output logic    jmp_abs_o,
  output logic    jmp_ind_o
);
  logic is_beqz, is_bnez;

  assign is_beqz    = (opcode_e_i == OPC_BEQZ);
  assign is_bnez    = (opcode_e_i == OPC_BNEZ);
  assign br_taken_o = (is_beqz && zero_e_i) || (is_bnez && !zero_e_i);

  assign jmp_abs_o  = (opcode_d_i == OPC_J)  || (opcode_d_i == OPC_JAL);
  assign jmp_ind_o  = (opcode_d_i == OPC_JR) || (opcode_d_i == OPC_JALR);
endmodule

// File: rtl/hz_raw_detect.sv
module hz_raw_detect #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned N_WR  = 3
) (
  input  logic [REG_W-1:0]           rs_i,
  input  logic                       rs_en_i,
  input  logic [REG_W-1:0]           rt_i,
  input  logic                       rt_en_i,
  input  logic [N_WR-1:0][REG_W-1:0] wr_reg_i,
  input  logic [N_WR-1:0]            wr_en_i,
  input  logic                       kill_i,
  output logic                       stall_o
);
  logic [N_WR-1:0] hit;

  for (genvar g = 0; g < N_WR; g++) begin : g_wr
    assign hit[g] = wr_en_i[g] &&
                    ((rs_en_i && (rs_i == wr_reg_i[g])) ||
                     (rt_en_i && (rt_i == wr_reg_i[g])));
  end

  // decode instruction is dead when the older branch redirects
  assign stall_o = (|hit) && !kill_i;
endmodule

// File: rtl/hz_select.sv
module hz_select
  import hz_pkg::*;
(
  input  logic     rst_ni,
  input  logic     br_taken_i,
  input  logic     jmp_abs_i,
  input  logic     jmp_ind_i,
  input  logic     stall_i,
  output pc_sel_e  pc_sel_o,
  output ird_sel_e ird_sel_o,
  output ire_sel_e ire_sel_o
);
  always_comb begin
    if (br_taken_i)     pc_sel_o = PC_BR;
    else if (jmp_abs_i) pc_sel_o = PC_JABS;
    else if (jmp_ind_i) pc_sel_o = PC_RIND;
    else                pc_sel_o = PC_SEQ;
  end

  always_comb begin
    if (!rst_ni || br_taken_i)        ird_sel_o = IRD_BUBBLE;
    else if (stall_i)                 ird_sel_o = IRD_HOLD;
    else if (jmp_abs_i || jmp_ind_i)  ird_sel_o = IRD_BUBBLE;
    else                              ird_sel_o = IRD_FETCH;
  end

  always_comb begin
    if (!rst_ni || br_taken_i || stall_i) ire_sel_o = IRE_BUBBLE;
    else                                  ire_sel_o = IRE_PASS;
  end
endmodule

// File: rtl/hz_pc_gen.sv
module hz_pc_gen
  import hz_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     OFF_W    = 16,
  parameter int unsigned     JT_W     = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pc_sel_e          pc_sel_i,
  input  logic             pc_en_i,
  input  logic [XLEN-1:0]  pc_d_i,
  input  logic [XLEN-1:0]  pc_e_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [JT_W-1:0]  jt_i,
  input  logic [XLEN-1:0]  rind_i,
  output logic [XLEN-1:0]  pc_o
);
  localparam int unsigned HI_W = XLEN - JT_W - 2;

  logic [XLEN-1:0] pc_q, pc_nxt, off_ext, jabs;
  logic            unused_pc_d_lo;

  assign off_ext        = {{(XLEN-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign jabs           = {pc_d_i[XLEN-1 -: HI_W], jt_i, 2'b00};
  assign unused_pc_d_lo = ^pc_d_i[JT_W+1:0];

  always_comb begin
    unique case (pc_sel_i)
      PC_BR:   pc_nxt = pc_e_i + off_ext;
      PC_JABS: pc_nxt = jabs;
      PC_RIND: pc_nxt = rind_i;
      default: pc_nxt = pc_q + XLEN'(4);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= RESET_PC;
    else if (pc_en_i) pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/hz_ctrl_top.sv
module hz_ctrl_top
  import hz_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     REG_W    = 5,
  parameter int unsigned     OFF_W    = 16,
  parameter int unsigned     JT_W     = 26,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [hz_pkg::OP_W-1:0]    opcode_d_i,
  input  logic [hz_pkg::OP_W-1:0]    opcode_e_i,
  input  logic                       zero_e_i,
  input  logic [REG_W-1:0]           rs_d_i,
  input  logic                       rs_rd_en_d_i,
  input  logic [REG_W-1:0]           rt_d_i,
  input  logic                       rt_rd_en_d_i,
  input  logic [REG_W-1:0]           wr_reg_e_i,
  input  logic                       wr_en_e_i,
  input  logic [REG_W-1:0]           wr_reg_m_i,
  input  logic                       wr_en_m_i,
  input  logic [REG_W-1:0]           wr_reg_w_i,
  input  logic                       wr_en_w_i,
  input  logic [XLEN-1:0]            pc_d_i,
  input  logic [XLEN-1:0]            pc_e_i,
  input  logic [OFF_W-1:0]           br_off_e_i,
  input  logic [JT_W-1:0]            jmp_tgt_d_i,
  input  logic [XLEN-1:0]            rind_tgt_d_i,
  output logic                       stall_o,
  output logic [1:0]                 pc_sel_o,
  output logic [1:0]                 ir_d_sel_o,
  output logic                       ir_e_sel_o,
  output logic [XLEN-1:0]            pc_o
);
  localparam int unsigned N_WR = 3;

  logic                       br_taken, jmp_abs, jmp_ind, stall;
  logic [N_WR-1:0][REG_W-1:0] wr_reg;
  logic [N_WR-1:0]            wr_en;
  pc_sel_e                    pc_sel;
  ird_sel_e                   ird_sel;
  ire_sel_e                   ire_sel;

  assign wr_reg = {wr_reg_w_i, wr_reg_m_i, wr_reg_e_i};
  assign wr_en  = {wr_en_w_i, wr_en_m_i, wr_en_e_i};

  hz_op_decode u_dec (
    .opcode_d_i (opcode_d_i),
    .opcode_e_i (opcode_e_i),
    .zero_e_i   (zero_e_i),
    .br_taken_o (br_taken),
    .jmp_abs_o  (jmp_abs),
    .jmp_ind_o  (jmp_ind)
  );

  hz_raw_detect #(.REG_W(REG_W), .N_WR(N_WR)) u_raw (
    .rs_i     (rs_d_i),
    .rs_en_i  (rs_rd_en_d_i),
    .rt_i     (rt_d_i),
    .rt_en_i  (rt_rd_en_d_i),
    .wr_reg_i (wr_reg),
    .wr_en_i  (wr_en),
    .kill_i   (br_taken),
    .stall_o  (stall)
  );

  hz_select u_sel (
    .rst_ni     (rst_ni),
    .br_taken_i (br_taken),
    .jmp_abs_i  (jmp_abs),
    .jmp_ind_i  (jmp_ind),
    .stall_i    (stall),
    .pc_sel_o   (pc_sel),
    .ird_sel_o  (ird_sel),
    .ire_sel_o  (ire_sel)
  );

  hz_pc_gen #(
    .XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W), .RESET_PC(RESET_PC)
  ) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pc_sel_i (pc_sel),
    .pc_en_i  (!stall),
    .pc_d_i   (pc_d_i),
    .pc_e_i   (pc_e_i),
    .off_i    (br_off_e_i),
    .jt_i     (jmp_tgt_d_i),
    .rind_i   (rind_tgt_d_i),
    .pc_o     (pc_o)
  );

  assign stall_o    = stall;
  assign pc_sel_o   = pc_sel;
  assign ir_d_sel_o = ird_sel;
  assign ir_e_sel_o = ire_sel;
endmodule

// File: rtl/hz_ctrl_checker.sv
module hz_ctrl_checker
  import hz_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned REG_W = 5,
  parameter int unsigned OFF_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OP_W-1:0]  opcode_d_i,
  input logic [OP_W-1:0]  opcode_e_i,
  input logic             zero_e_i,
  input logic [REG_W-1:0] rs_d_i,
  input logic             rs_rd_en_d_i,
  input logic [REG_W-1:0] wr_reg_e_i,
  input logic             wr_en_e_i,
  input logic [XLEN-1:0]  pc_e_i,
  input logic [OFF_W-1:0] br_off_e_i,
  input logic             stall_o,
  input logic [1:0]       pc_sel_o,
  input logic [1:0]       ir_d_sel_o,
  input logic             ir_e_sel_o,
  input logic [XLEN-1:0]  pc_o
);
  logic            tk, jd;
  logic [XLEN-1:0] br_tgt;

  assign tk = ((opcode_e_i == OPC_BEQZ) && zero_e_i) ||
              ((opcode_e_i == OPC_BNEZ) && !zero_e_i);
  assign jd = (opcode_d_i == OPC_J) || (opcode_d_i == OPC_JAL) ||
              (opcode_d_i == OPC_JR) || (opcode_d_i == OPC_JALR);
  assign br_tgt = pc_e_i + {{(XLEN-OFF_W){br_off_e_i[OFF_W-1]}}, br_off_e_i};

  p_exec_hit_stall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_rd_en_d_i && wr_en_e_i && (rs_d_i == wr_reg_e_i) && !tk) |-> stall_o);

  p_taken_no_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |-> !stall_o);

  p_taken_sel_br_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |-> (pc_sel_o == 2'd3));

  p_jump_kills_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jd && !tk && !stall_o) |-> (ir_d_sel_o == 2'd1) && !ir_e_sel_o);

  p_stall_bubbles_exec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ir_e_sel_o);

  p_stall_holds_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_o));

  p_branch_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |=> (pc_o == $past(br_tgt)));

  p_taken_kills_two_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk |-> (ir_d_sel_o == 2'd1) && ir_e_sel_o);
endmodule

bind hz_ctrl_top hz_ctrl_checker #(
  .XLEN(XLEN), .REG_W(REG_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .opcode_d_i   (opcode_d_i),
  .opcode_e_i   (opcode_e_i),
  .zero_e_i     (zero_e_i),
  .rs_d_i       (rs_d_i),
  .rs_rd_en_d_i (rs_rd_en_d_i),
  .wr_reg_e_i   (wr_reg_e_i),
  .wr_en_e_i    (wr_en_e_i),
  .pc_e_i       (pc_e_i),
  .br_off_e_i   (br_off_e_i),
  .stall_o      (stall_o),
  .pc_sel_o     (pc_sel_o),
  .ir_d_sel_o   (ir_d_sel_o),
  .ir_e_sel_o   (ir_e_sel_o),
  .pc_o         (pc_o)
);

// File: tb/tb_hz_ctrl_top.sv
module tb_hz_ctrl_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC     = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opd, ope;
  logic        zero;
  logic [4:0]  rs, rt, wre, wrm, wrw;
  logic        rse, rte, ene, enm, enw;
  logic [31:0] pcd, pce, rind, pc;
  logic [15:0] off;
  logic [25:0] jt;
  logic        stall, esel;
  logic [1:0]  psel, dsel;

  typedef struct {
    logic [5:0] opd, ope; logic z;
    logic [4:0] rs, rt, we, wm, ww; logic rse, rte, ene, enm, enw;
    logic [15:0] off; logic [25:0] jt; logic [31:0] rind, pcd, pce;
  } stim_t;

  typedef struct {
    string tag; logic stall; logic [1:0] psel, dsel; logic esel; logic [31:0] npc;
  } exp_t;

  exp_t        q[$];
  event        drv_ev;
  int          total = 0, bad = 0;
  logic [31:0] exp_pc = RST_PC;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_ctrl_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_d_i(opd), .opcode_e_i(ope), .zero_e_i(zero),
    .rs_d_i(rs), .rs_rd_en_d_i(rse), .rt_d_i(rt), .rt_rd_en_d_i(rte),
    .wr_reg_e_i(wre), .wr_en_e_i(ene), .wr_reg_m_i(wrm), .wr_en_m_i(enm),
    .wr_reg_w_i(wrw), .wr_en_w_i(enw), .pc_d_i(pcd), .pc_e_i(pce),
    .br_off_e_i(off), .jmp_tgt_d_i(jt), .rind_tgt_d_i(rind),
    .stall_o(stall), .pc_sel_o(psel), .ir_d_sel_o(dsel), .ir_e_sel_o(esel), .pc_o(pc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic stim_t base();
    stim_t s;
    s.opd = 6'h00; s.ope = 6'h00; s.z = 1'b0;
    s.rs = 5'd1; s.rt = 5'd2; s.we = 5'd3; s.wm = 5'd4; s.ww = 5'd5;
    s.rse = 1'b0; s.rte = 1'b0; s.ene = 1'b0; s.enm = 1'b0; s.enw = 1'b0;
    s.off = 16'h0040; s.jt = 26'h0000123; s.rind = 32'h0000_8000;
    s.pcd = 32'hA000_0010; s.pce = 32'h0000_2000;
    return s;
  endfunction

  // driver: apply on falling edge, push expectation built from the requirements
  task automatic apply(string tag, stim_t s);
    exp_t e; logic tk, raw, ja, ji; logic [31:0] tgt;
    @(negedge clk);
    opd = s.opd; ope = s.ope; zero = s.z; rs = s.rs; rt = s.rt; rse = s.rse; rte = s.rte;
    wre = s.we; wrm = s.wm; wrw = s.ww; ene = s.ene; enm = s.enm; enw = s.enw;
    off = s.off; jt = s.jt; rind = s.rind; pcd = s.pcd; pce = s.pce;
    tk  = (s.ope == 6'h04 && s.z) || (s.ope == 6'h05 && !s.z);
    ja  = (s.opd == 6'h02) || (s.opd == 6'h03);
    ji  = (s.opd == 6'h12) || (s.opd == 6'h13);
    raw = (s.rse && ((s.ene && s.rs == s.we) || (s.enm && s.rs == s.wm) || (s.enw && s.rs == s.ww))) ||
          (s.rte && ((s.ene && s.rt == s.we) || (s.enm && s.rt == s.wm) || (s.enw && s.rt == s.ww)));
    e.tag   = tag;
    e.stall = raw && !tk;
    e.psel  = tk ? 2'd3 : ja ? 2'd1 : ji ? 2'd2 : 2'd0;
    e.dsel  = tk ? 2'd1 : e.stall ? 2'd2 : (ja || ji) ? 2'd1 : 2'd0;
    e.esel  = tk || e.stall;
    case (e.psel)
      2'd3:    tgt = s.pce + {{16{s.off[15]}}, s.off};
      2'd1:    tgt = {s.pcd[31:28], s.jt, 2'b00};
      2'd2:    tgt = s.rind;
      default: tgt = exp_pc + 32'd4;
    endcase
    e.npc  = e.stall ? exp_pc : tgt;
    exp_pc = e.npc;
    q.push_back(e);
    -> drv_ev;
  endtask

  // monitor: compare combinational selects mid-cycle, PC after the edge
  initial begin
    exp_t e;
    forever begin
      @(drv_ev);
      #1;
      e = q.pop_front();
      chk(e.tag, "stall", {31'd0, stall}, {31'd0, e.stall});
      chk(e.tag, "pc_sel", {30'd0, psel}, {30'd0, e.psel});
      chk(e.tag, "ir_d_sel", {30'd0, dsel}, {30'd0, e.dsel});
      chk(e.tag, "ir_e_sel", {31'd0, esel}, {31'd0, e.esel});
      @(posedge clk);
      #1;
      chk(e.tag, "pc", pc, e.npc);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    stim_t s;
    s = base();
    opd = s.opd; ope = s.ope; zero = 1'b0; rs = s.rs; rt = s.rt; rse = 1'b1; rte = 1'b0;
    wre = 5'd1; wrm = s.wm; wrw = s.ww; ene = 1'b1; enm = 1'b0; enw = 1'b0;
    off = s.off; jt = s.jt; rind = s.rind; pcd = s.pcd; pce = s.pce;
    // R8: reset state, even with a hazard on the inputs
    repeat (2) @(posedge clk);
    #2;
    chk("R8", "pc", pc, RST_PC);
    chk("R8", "ir_d_sel", {30'd0, dsel}, 32'd1);
    chk("R8", "ir_e_sel", {31'd0, esel}, 32'd1);
    @(negedge clk);
    rst_ni = 1'b1;

    s = base(); apply("R7 sequential", s);
    s = base(); s.rs = 5'd3; s.rse = 1'b1; s.ene = 1'b1; apply("R1 rs hits exec", s);
    s = base(); s.rt = 5'd4; s.rte = 1'b1; s.enm = 1'b1; apply("R1 rt hits mem", s);
    s = base(); s.rs = 5'd5; s.rse = 1'b1; s.enw = 1'b1; apply("R1 rs hits wb", s);
    s = base(); s.rs = 5'd3; s.rse = 1'b1; apply("R1 writer disabled", s);
    s = base(); s.rs = 5'd3; s.ene = 1'b1; apply("R1 reader disabled", s);
    s = base(); s.opd = 6'h02; apply("R3 J absolute", s);
    s = base(); s.opd = 6'h12; apply("R3 JR indirect", s);
    s = base(); s.opd = 6'h03; s.jt = 26'h3FF_FFFF; apply("R4 JAL bubbles decode", s);
    s = base(); s.opd = 6'h13; s.rind = 32'h0000_4444; apply("R5 JALR passes exec", s);
    s = base(); s.ope = 6'h04; s.z = 1'b1; s.rs = 5'd3; s.rse = 1'b1; s.ene = 1'b1;
    apply("R2 BEQZ taken cancels stall", s);
    s = base(); s.ope = 6'h04; s.z = 1'b0; apply("R2 BEQZ not taken", s);
    s = base(); s.ope = 6'h05; s.z = 1'b0; s.opd = 6'h02; apply("R9 branch beats jump", s);
    s = base(); s.ope = 6'h05; s.z = 1'b1; s.opd = 6'h12; apply("R2 BNEZ not taken", s);
    s = base(); s.opd = 6'h02; s.rt = 5'd3; s.rte = 1'b1; s.ene = 1'b1; apply("R6 stall holds jump", s);
    s = base(); s.ope = 6'h04; s.z = 1'b1; s.off = 16'hFFF0; apply("R7 negative offset", s);
    s = base(); apply("R5 clean pass", s);

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule